// File: doc/BRIEF.md
# Instruction Pair Test Sequencer

This block produces the order in which instructions are issued during a functional processor test aimed at side-effect faults. Each instruction of a set of `N` is identified by an index from 0 to N-1. After a start request the block first walks through all indices one at a time. This single-instruction phase lets a downstream checker confirm that each instruction does what it should.

It then walks through every ordered pair. A pair consists of a first instruction and, right after it, a second one. Pairs of an instruction with itself are included. An unwanted state change left behind by the first instruction then shows up as a wrong result from the second.

Each issued index is held on the output until the consumer accepts it with an advance strobe. The outputs also carry a phase tag, a tag for the position within the pair, and a done flag. The pair phase can run once and stop, or it can repeat without end. One full pass issues N + 2·N² indices.

Top module: `instr_pair_sequencer`

## Requirements
- R1: After reset, and until a start is accepted, `valid_o`=0, `done_o`=0 and `idx_o`=0.
- R2: A `start_i` pulse seen while neither `valid_o` nor `done_o` is high makes the next cycle show `valid_o`=1, `phase_o`=0 (single phase) and `idx_o`=0.
- R3: In the single phase the indices 0,1,…,N-1 are issued in order. An index stays on `idx_o`, with its tags unchanged, until a cycle in which `valid_o` and `adv_i` are both 1. The index then steps on the following cycle.
- R4: Advancing past single index N-1 enters the pair phase (`phase_o`=1). Pairs (a,b) are enumerated with a as the outer loop and b as the inner loop, each from 0 to N-1. Each pair issues a with `slot_o`=0 and then b with `slot_o`=1.
- R5: One pass contains every ordered pair, including a=b, so a single-shot run accepts exactly N + 2·N² advances from start to done.
- R6: In single-shot mode, advancing past the second slot of pair (N-1,N-1) gives `done_o`=1 with `valid_o`=0. This state holds until a new start.
- R7: In cyclic mode, advancing past pair (N-1,N-1) restarts at pair (0,0), slot 0, with `phase_o`=1. The single phase is not repeated and `done_o` never rises.
- R8: `cyclic_i` is sampled only when a start is accepted. While `valid_o`=1, neither `start_i` nor changes of `cyclic_i` have any effect on the issued sequence.
- R9: A `start_i` pulse while `done_o`=1 restarts the run at single index 0 and clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle or done |
| cyclic_i | input | 1 | 1 = repeat the pair phase without end, 0 = single-shot; sampled at start |
| adv_i | input | 1 | Consumer accepts the current index |
| valid_o | output | 1 | An index is being issued |
| idx_o | output | IDX_W | Current instruction index |
| phase_o | output | 1 | 0 = single phase, 1 = pair phase |
| slot_o | output | 1 | In the pair phase: 0 = first of pair, 1 = second |
| done_o | output | 1 | Single-shot run completed |

## Verification
Every output is a registered result. A start or an advance seen at one rising edge shows up in the outputs directly after that edge, and without an advance the outputs keep their values. The bench updates its behavioural model on the same edge from the same inputs. It compares all outputs at the next falling edge, while inputs change only shortly after falling edges, so each comparison sees exactly one cycle of latency. The advance count for a single-shot pass is accumulated at rising edges from `valid_o` and `adv_i` and compared with N + 2·N² when `done_o` rises.

// File: rtl/ips_pkg.sv
package ips_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SINGLE = 3'd1,
    ST_PAIR_A = 3'd2,
    ST_PAIR_B = 3'd3,
    ST_DONE   = 3'd4
  } ips_state_e;

  localparam int unsigned CNT_OUTER = 0;
  localparam int unsigned CNT_INNER = 1;
  localparam int unsigned NUM_CNT   = 2;

endpackage

// File: rtl/ips_wrap_cnt.sv
module ips_wrap_cnt #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);

  localparam logic [W-1:0] LAST_VAL = W'(N - 1);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_en = clr_i | inc_i;
    if (clr_i) begin
      val_d = '0;
    end else if (val_q == LAST_VAL) begin
      val_d = '0;
    end else begin
      val_d = val_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val_o  = val_q;
  assign last_o = (val_q == LAST_VAL);

endmodule

// File: rtl/ips_ctrl.sv
module ips_ctrl
  import ips_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cyclic_i,
  input  logic               adv_i,
  input  logic               outer_last_i,
  input  logic               inner_last_i,
  output ips_state_e         state_o,
  output logic [NUM_CNT-1:0] clr_o,
  output logic [NUM_CNT-1:0] inc_o
);

  ips_state_e state_q;
  ips_state_e state_d;
  logic       cyc_q;
  logic       cyc_d;
  logic       cyc_en;
  logic       issuing;
  logic       fire;

  always_comb begin
    issuing = (state_q == ST_SINGLE) || (state_q == ST_PAIR_A) ||
              (state_q == ST_PAIR_B);
    fire    = issuing & adv_i;
  end

  always_comb begin
    state_d = state_q;
    clr_o   = '0;
    inc_o   = '0;
    cyc_en  = 1'b0;
    cyc_d   = cyc_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_SINGLE;
          clr_o   = '1;
          cyc_en  = 1'b1;
          cyc_d   = cyclic_i;
        end
      end
      ST_SINGLE: begin
        if (fire) begin
          if (outer_last_i) begin
            state_d = ST_PAIR_A;
            clr_o   = '1;
          end else begin
            inc_o[CNT_OUTER] = 1'b1;
          end
        end
      end
      ST_PAIR_A: begin
        if (fire) begin
          state_d = ST_PAIR_B;
        end
      end
      ST_PAIR_B: begin
        if (fire) begin
          if (inner_last_i) begin
            clr_o[CNT_INNER] = 1'b1;
            if (outer_last_i) begin
              clr_o[CNT_OUTER] = 1'b1;
              state_d = cyc_q ? ST_PAIR_A : ST_DONE;
            end else begin
              inc_o[CNT_OUTER] = 1'b1;
              state_d = ST_PAIR_A;
            end
          end else begin
            inc_o[CNT_INNER] = 1'b1;
            state_d = ST_PAIR_A;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        clr_o   = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 1'b0;
    end else if (cyc_en) begin
      cyc_q <= cyc_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/instr_pair_sequencer.sv
module instr_pair_sequencer
  import ips_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cyclic_i,
  input  logic             adv_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             phase_o,
  output logic             slot_o,
  output logic             done_o
);

  ips_state_e               state;
  logic [NUM_CNT-1:0]       cnt_clr;
  logic [NUM_CNT-1:0]       cnt_inc;
  logic [NUM_CNT-1:0]       cnt_last;
  logic [NUM_CNT-1:0][IDX_W-1:0] cnt_val;

  ips_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cyclic_i     (cyclic_i),
    .adv_i        (adv_i),
    .outer_last_i (cnt_last[CNT_OUTER]),
    .inner_last_i (cnt_last[CNT_INNER]),
    .state_o      (state),
    .clr_o        (cnt_clr),
    .inc_o        (cnt_inc)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ips_wrap_cnt #(
      .N (N),
      .W (IDX_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr[g]),
      .inc_i  (cnt_inc[g]),
      .val_o  (cnt_val[g]),
      .last_o (cnt_last[g])
    );
  end

  always_comb begin
    valid_o = (state == ST_SINGLE) || (state == ST_PAIR_A) ||
              (state == ST_PAIR_B);
    phase_o = (state == ST_PAIR_A) || (state == ST_PAIR_B);
    slot_o  = (state == ST_PAIR_B);
    done_o  = (state == ST_DONE);
    idx_o   = slot_o ? cnt_val[CNT_INNER] : cnt_val[CNT_OUTER];
  end

endmodule

// File: rtl/ips_checker.sv
module ips_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             adv_i,
  input logic             valid_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             phase_o,
  input logic             slot_o,
  input logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  // R1 / R6: never issuing and done at once
  p_done_not_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !done_o && start_i) |=> (valid_o && !phase_o && idx_o == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i) |=> (valid_o && $stable(idx_o) && $stable(phase_o) && $stable(slot_o)));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !phase_o && idx_o != LAST_IDX) |=>
      (valid_o && !phase_o && idx_o == $past(idx_o) + IDX_W'(1)));

  p_enter_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !phase_o && idx_o == LAST_IDX) |=>
      (valid_o && phase_o && !slot_o && idx_o == '0));

  p_slot_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && phase_o && !slot_o) |=> (valid_o && phase_o && slot_o));

  p_restart_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (valid_o && !done_o && !phase_o && idx_o == '0));

endmodule

bind instr_pair_sequencer ips_checker #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .adv_i   (adv_i),
  .valid_o (valid_o),
  .idx_o   (idx_o),
  .phase_o (phase_o),
  .slot_o  (slot_o),
  .done_o  (done_o)
);

// File: tb/instr_pair_sequencer_tb.sv
module instr_pair_sequencer_tb;

  localparam int N          = 8;
  localparam int IDX_W      = $clog2(N);
  localparam int CLK_PERIOD = 10;
  localparam int LEN        = N + 2 * N * N;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic             cyclic_i;
  logic             adv_i;
  logic             valid_o;
  logic [IDX_W-1:0] idx_o;
  logic             phase_o;
  logic             slot_o;
  logic             done_o;

  instr_pair_sequencer #(.N(N)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cyclic_i (cyclic_i),
    .adv_i    (adv_i),
    .valid_o  (valid_o),
    .idx_o    (idx_o),
    .phase_o  (phase_o),
    .slot_o   (slot_o),
    .done_o   (done_o)
  );

  int n_tests;
  int n_fail;
  bit finished;

  // expected sequence for one pass
  int exp_ph[$];
  int exp_sl[$];
  int exp_ix[$];

  // behavioural model
  bit m_busy;
  bit m_done;
  bit m_cyc;
  int m_pos;
  int dut_fires;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    for (int i = 0; i < N; i++) begin
      exp_ph.push_back(0); exp_sl.push_back(0); exp_ix.push_back(i);
    end
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        exp_ph.push_back(1); exp_sl.push_back(0); exp_ix.push_back(a);
        exp_ph.push_back(1); exp_sl.push_back(1); exp_ix.push_back(b);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_done <= 1'b0;
      m_cyc  <= 1'b0;
      m_pos  <= 0;
    end else if (!m_busy) begin
      if (start_i) begin
        m_busy <= 1'b1;
        m_done <= 1'b0;
        m_pos  <= 0;
        m_cyc  <= cyclic_i;
      end
    end else if (adv_i) begin
      if (m_pos == LEN - 1) begin
        if (m_cyc) m_pos <= N;
        else begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
        end
      end else begin
        m_pos <= m_pos + 1;
      end
    end
    if (rst_n && valid_o && adv_i) dut_fires <= dut_fires + 1;
  end

  function automatic string tag_now();
    if (m_done) return "R6";
    if (!m_busy) return "R1";
    if (m_pos < N) return "R3";
    if (m_cyc) return "R7";
    return "R4";
  endfunction

  // cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit bad;
      int e_ix, e_ph, e_sl;
      e_ix = m_busy ? exp_ix[m_pos] : 0;
      e_ph = m_busy ? exp_ph[m_pos] : 0;
      e_sl = m_busy ? exp_sl[m_pos] : 0;
      bad = (valid_o !== m_busy) || (done_o !== m_done);
      if (m_busy)
        bad = bad || (int'(idx_o) != e_ix) || (int'(phase_o) != e_ph) ||
              (int'(slot_o) != e_sl);
      else if (!m_done)
        bad = bad || (idx_o !== '0);
      n_tests++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s pos=%0d: valid=%0b done=%0b idx=%0d ph=%0b sl=%0b exp valid=%0b done=%0b idx=%0d ph=%0d sl=%0d",
                 tag_now(), m_pos, valid_o, done_o, idx_o, phase_o, slot_o,
                 m_busy, m_done, e_ix, e_ph, e_sl);
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input bit s, input bit c, input bit a);
    @(negedge clk);
    #1;
    start_i  = s;
    cyclic_i = c;
    adv_i    = a;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k;
    n_tests = 0; n_fail = 0; finished = 1'b0; dut_fires = 0;
    rst_n = 1'b0; start_i = 1'b0; cyclic_i = 1'b0; adv_i = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", valid_o, 0);
    check("R1 done", done_o, 0);
    check("R1 idx", idx_o, 0);

    // idle with advance only: nothing happens (R1)
    repeat (4) drive(1'b0, 1'b0, 1'b1);

    // single-shot start (R2)
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    dut_fires = 0;
    @(negedge clk);
    check("R2 valid", valid_o, 1);
    check("R2 phase", phase_o, 0);
    check("R2 idx", idx_o, 0);

    // run with stalls; stray start and cyclic changes must be ignored (R8)
    k = 0;
    while (!done_o && k < 4 * LEN) begin
      drive((k == 20) || (k == 150), (k % 7) == 3, (k % 3) != 1);
      k++;
    end
    drive(1'b0, 1'b0, 1'b0);
    check("R6 done after single-shot pass", done_o, 1);
    check("R5 advances in one pass", dut_fires, LEN);

    // done holds with advance asserted (R6)
    repeat (5) drive(1'b0, 1'b1, 1'b1);
    check("R6 done held", done_o, 1);

    // restart from done in cyclic mode (R9), then run several passes (R7)
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 restart valid", valid_o, 1);
    check("R9 restart idx", idx_o, 0);
    check("R9 restart phase", phase_o, 0);
    for (int c = 0; c < 3 * LEN; c++) begin
      drive(c == 77, (c % 5) == 0, (c % 4) != 2);
    end
    check("R7 never done in cyclic mode", done_o, 0);
    check("R7 still issuing pairs", phase_o, 1);

    // asynchronous reset mid-run (R1)
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", valid_o, 0);
    check("R1 idx after reset", idx_o, 0);
    repeat (2) drive(1'b0, 1'b0, 1'b0);
    finish_run();
  end

endmodule